// File: doc/BRIEF.md
# Ring Buffer Sample Writer

This block produces the write side of a sample store that treats a large external memory as a ring. The acquisition controller sends it a start pulse, a strobe for each 64-bit sample word (four 16-bit channel values), a pulse when a trigger has been accepted, and a pulse when the shot is over. The block puts a word address, a data word and a write enable on the memory port. A write stalls for as long as the memory holds its ready low. The pointer moves only when the memory accepts a write. When the pointer passes the last word it goes back to zero, so older samples are overwritten.

When a trigger arrives, the block stores the pointer as a byte address in a register the host can read. The host uses it to find the samples around the trigger. When the shot ends, the block writes two time-tag words straight after the last sample and then goes idle.

The controller has four states:
- `ST_IDLE`: no writes.
- `ST_CAPTURE`: writes the samples.
- `ST_TAG_HI`: writes the first time-tag word.
- `ST_TAG_LO`: writes the second time-tag word.

Transitions:
- Start: from any state to `ST_CAPTURE`.
- Shot end: from `ST_CAPTURE` to `ST_TAG_HI`.
- Accepted first tag: from `ST_TAG_HI` to `ST_TAG_LO`.
- Accepted second tag: from `ST_TAG_LO` to `ST_IDLE`.

Top module: `ring_wr_top`

## Requirements
- R1: After reset the word address is 0, the trigger byte address is 0, the write enable is low, the sample-ready output is low and the state is idle.
- R2: A start pulse in any state sets the word address to 0 on the next cycle and enters capture. No write is issued in the cycle of the start pulse.
- R3: In capture, a sample strobe raises the write enable with the sample word unchanged on the data output. Each accepted write (enable and memory ready both high) moves the address up by one.
- R4: An accepted write at address WORDS-1 is followed by address 0.
- R5: While the memory ready is low, the address does not move. The sample-ready output is high only in capture with the memory ready high and no start pulse.
- R6: A trigger pulse in capture loads the trigger register with the current word address multiplied by 8 (word address shifted left by three).
- R7: A trigger pulse outside capture leaves the trigger register unchanged.
- R8: A shot-end pulse in capture stores both tag inputs at that edge. The next two accepted writes carry the high tag word and then the low tag word, at the two addresses that follow the last sample, with wrap. The block is then idle.
- R9: When a start pulse coincides with a shot-end or trigger pulse, the start wins. The block stays in capture at address 0, and the trigger register is not loaded.
- R10: Outside capture and the tag states, sample strobes produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_start_i | input | 1 | Start-of-acquisition pulse |
| trig_ok_i | input | 1 | Trigger-accepted pulse |
| shot_end_i | input | 1 | End-of-shot pulse |
| smp_valid_i | input | 1 | Sample word strobe |
| smp_data_i | input | 64 | Sample word, four 16-bit channels |
| smp_ready_o | output | 1 | Sample word is being taken this cycle |
| tag_hi_i | input | 64 | First time-tag word |
| tag_lo_i | input | 64 | Second time-tag word |
| mem_rdy_i | input | 1 | Memory accepts the write |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | $clog2(WORDS) | Memory word address |
| mem_data_o | output | 64 | Memory write data |
| trig_addr_o | output | $clog2(WORDS)+3 | Byte address latched at trigger |

## Verification
The hardest situations to reach are shot ends and triggers that land right at the wrap point, or while the memory is stalling a tag write. A plain run of samples rarely lines these up. The bench uses a small ring of 16 words so the pointer wraps many times. Random stimulus mixes in ready gaps and rare start and shot-end pulses, including start pulses during tag writes and pulses that coincide. Directed steps cover the coincident-pulse priority and triggers sent while idle.

// File: rtl/ring_wr_pkg.sv
package ring_wr_pkg;
    localparam int CHAN_W   = 16;
    localparam int CHANNELS = 4;
    localparam int WORD_W   = CHAN_W * CHANNELS;
    localparam int BYTE_SH  = $clog2(WORD_W / 8);

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_TAG_HI  = 2'd2,
        ST_TAG_LO  = 2'd3
    } wr_state_e;
endpackage

// File: rtl/ring_wr_ptr.sv
module ring_wr_ptr #(
    parameter int WORDS = 16,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] TOP = AW'(WORDS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == TOP) ? '0 : ptr + AW'(1);
        end
    end
endmodule

// File: rtl/ring_wr_trig.sv
module ring_wr_trig #(
    parameter int AW = 4,
    parameter int SH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [AW-1:0]    ptr,
    output logic [AW+SH-1:0] byte_addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_addr <= '0;
        end else if (capture) begin
            byte_addr <= {ptr, {SH{1'b0}}};
        end
    end
endmodule

// File: rtl/ring_wr_tags.sv
module ring_wr_tags #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] hi_in,
    input  logic [W-1:0] lo_in,
    output logic [W-1:0] hi_q,
    output logic [W-1:0] lo_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (load) begin
            hi_q <= hi_in;
            lo_q <= lo_in;
        end
    end
endmodule

// File: rtl/ring_wr_top.sv
module ring_wr_top
    import ring_wr_pkg::*;
#(
    parameter int WORDS = 33554432,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acq_start_i,
    input  logic                trig_ok_i,
    input  logic                shot_end_i,
    input  logic                smp_valid_i,
    input  logic [WORD_W-1:0]   smp_data_i,
    output logic                smp_ready_o,
    input  logic [WORD_W-1:0]   tag_hi_i,
    input  logic [WORD_W-1:0]   tag_lo_i,
    input  logic                mem_rdy_i,
    output logic                mem_we_o,
    output logic [AW-1:0]       mem_addr_o,
    output logic [WORD_W-1:0]   mem_data_o,
    output logic [AW+BYTE_SH-1:0] trig_addr_o
);
    wr_state_e st_q, st_d;
    logic [AW-1:0]     ptr;
    logic [WORD_W-1:0] tag_hi_q, tag_lo_q;
    logic              advance, trig_cap, tag_load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (acq_start_i) st_d = ST_CAPTURE;
            ST_CAPTURE: begin
                if (acq_start_i)     st_d = ST_CAPTURE;
                else if (shot_end_i) st_d = ST_TAG_HI;
            end
            ST_TAG_HI: begin
                if (acq_start_i)    st_d = ST_CAPTURE;
                else if (mem_rdy_i) st_d = ST_TAG_LO;
            end
            ST_TAG_LO: begin
                if (acq_start_i)    st_d = ST_CAPTURE;
                else if (mem_rdy_i) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_we_o    = 1'b0;
        mem_data_o  = smp_data_i;
        smp_ready_o = 1'b0;
        trig_cap    = 1'b0;
        tag_load    = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_CAPTURE: begin
                mem_we_o    = smp_valid_i && !acq_start_i;
                smp_ready_o = mem_rdy_i && !acq_start_i;
                trig_cap    = trig_ok_i && !acq_start_i;
                tag_load    = shot_end_i && !acq_start_i;
            end
            ST_TAG_HI: begin
                mem_we_o   = !acq_start_i;
                mem_data_o = tag_hi_q;
            end
            ST_TAG_LO: begin
                mem_we_o   = !acq_start_i;
                mem_data_o = tag_lo_q;
            end
            default: ;
        endcase
        advance = mem_we_o && mem_rdy_i;
    end

    assign mem_addr_o = ptr;

    ring_wr_ptr #(.WORDS(WORDS)) ptr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (acq_start_i),
        .advance (advance),
        .ptr     (ptr)
    );

    ring_wr_trig #(.AW(AW), .SH(BYTE_SH)) trig_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (trig_cap),
        .ptr       (ptr),
        .byte_addr (trig_addr_o)
    );

    ring_wr_tags #(.W(WORD_W)) tags_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tag_load),
        .hi_in (tag_hi_i),
        .lo_in (tag_lo_i),
        .hi_q  (tag_hi_q),
        .lo_q  (tag_lo_q)
    );
endmodule

// File: rtl/ring_wr_chk.sv
module ring_wr_chk
    import ring_wr_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int AW   = $clog2(WORDS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   acq_start_i,
    input logic                   trig_ok_i,
    input logic                   mem_rdy_i,
    input logic                   mem_we_o,
    input logic                   smp_ready_o,
    input logic [AW-1:0]          mem_addr_o,
    input logic [AW+BYTE_SH-1:0]  trig_addr_o,
    input wr_state_e              st_q
);
    localparam logic [AW-1:0] TOP = AW'(WORDS - 1);

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start_i |=> (mem_addr_o == '0) && (st_q == ST_CAPTURE)); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && mem_rdy_i && !acq_start_i && mem_addr_o != TOP)
        |=> mem_addr_o == $past(mem_addr_o) + AW'(1)); // R3

    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && mem_rdy_i && !acq_start_i && mem_addr_o == TOP)
        |=> mem_addr_o == '0); // R4

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rdy_i && !acq_start_i) |=> $stable(mem_addr_o)); // R5

    AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready_o |-> (mem_rdy_i && st_q == ST_CAPTURE)); // R5

    AST_TRIG_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_ok_i && st_q == ST_CAPTURE && !acq_start_i)
        |=> trig_addr_o == {$past(mem_addr_o), 3'b000}); // R6

    AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_CAPTURE || acq_start_i) |=> $stable(trig_addr_o)); // R7

    AST_IDLE_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !mem_we_o); // R10
endmodule

bind ring_wr_top ring_wr_chk #(.WORDS(WORDS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acq_start_i (acq_start_i),
    .trig_ok_i   (trig_ok_i),
    .mem_rdy_i   (mem_rdy_i),
    .mem_we_o    (mem_we_o),
    .smp_ready_o (smp_ready_o),
    .mem_addr_o  (mem_addr_o),
    .trig_addr_o (trig_addr_o),
    .st_q        (st_q)
);

// File: tb/ring_wr_top_tb_top.sv
module ring_wr_top_tb_top;
    localparam int WORDS = 16;
    localparam int AW    = $clog2(WORDS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acq_start = 0, trig_ok = 0, shot_end = 0, smp_valid = 0, mem_rdy = 0;
    logic [63:0] smp_data = '0, tag_hi = '0, tag_lo = '0;
    logic smp_ready, mem_we;
    logic [AW-1:0] mem_addr;
    logic [63:0] mem_data;
    logic [AW+2:0] trig_addr;

    int n_chk = 0, n_fail = 0;

    int m_st = 0, m_ptr = 0, m_trig = 0;
    logic [63:0] m_ta = '0, m_tb = '0;
    string m_areq = "R1", m_treq = "R1";
    bit m_prio = 0;

    always #2.5 clk = ~clk;

    ring_wr_top #(.WORDS(WORDS)) dut_i (
        .clk(clk), .rst_n(rst_n), .acq_start_i(acq_start), .trig_ok_i(trig_ok),
        .shot_end_i(shot_end), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
        .smp_ready_o(smp_ready), .tag_hi_i(tag_hi), .tag_lo_i(tag_lo),
        .mem_rdy_i(mem_rdy), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_data_o(mem_data), .trig_addr_o(trig_addr)
    );

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int next_ptr(int p);
        return (p == WORDS - 1) ? 0 : p + 1;
    endfunction

    task automatic step(bit v, logic [63:0] d, bit rdy, bit st, bit tr, bit en,
                        logic [63:0] ta, logic [63:0] tb);
        bit exp_we, exp_sr;
        logic [63:0] exp_d;
        string wreq;
        @(negedge clk);
        smp_valid = v; smp_data = d; mem_rdy = rdy; acq_start = st;
        trig_ok = tr; shot_end = en; tag_hi = ta; tag_lo = tb;
        #1;
        exp_we = !st && ((m_st == 1 && v) || m_st >= 2);
        exp_sr = (m_st == 1) && rdy && !st;
        exp_d  = (m_st == 2) ? m_ta : (m_st == 3) ? m_tb : d;
        wreq = st ? "R2" : m_prio ? "R9" : (m_st == 0) ? "R10" : (m_st == 1) ? "R3" : "R8";
        chk(mem_we == exp_we, wreq, "mem_we", 64'(mem_we), 64'(exp_we));
        chk(mem_addr == AW'(m_ptr), m_areq, "mem_addr", 64'(mem_addr), 64'(m_ptr));
        if (exp_we)
            chk(mem_data == exp_d, (m_st >= 2) ? "R8" : "R3", "mem_data", mem_data, exp_d);
        chk(smp_ready == exp_sr, "R5", "smp_ready", 64'(smp_ready), 64'(exp_sr));
        chk(trig_addr == (AW+3)'(m_trig), m_treq, "trig_addr", 64'(trig_addr), 64'(m_trig));
        // reference update for the coming edge
        m_prio = 0;
        m_treq = "R6";
        if (st) begin
            if (m_st != 0 && (tr || en)) begin m_prio = 1; m_treq = "R9"; end
            m_st = 1; m_ptr = 0; m_areq = "R2";
        end else begin
            m_areq = (m_st >= 2) ? "R8" : "R3";
            if (exp_we && rdy) begin
                if (m_ptr == WORDS - 1) m_areq = "R4";
                m_ptr = next_ptr(m_ptr);
            end else if (exp_we) begin
                m_areq = "R5";
            end
            if (tr && m_st != 1) m_treq = "R7";
            case (m_st)
                1: begin
                    if (tr) m_trig = (exp_we && rdy ? (m_ptr == 0 ? WORDS - 1 : m_ptr - 1) : m_ptr) * 8;
                    if (en) begin m_ta = ta; m_tb = tb; m_st = 2; end
                end
                2: if (rdy) m_st = 3;
                3: if (rdy) m_st = 0;
                default: ;
            endcase
        end
    endtask

    function automatic logic [63:0] pat(int i);
        return {16'(i), 16'(i + 1), 16'(~i), 16'hA5A5};
    endfunction

    initial begin
        #200000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(mem_addr == '0, "R1", "reset mem_addr", 64'(mem_addr), 0);
        chk(trig_addr == '0, "R1", "reset trig_addr", 64'(trig_addr), 0);
        chk(mem_we == 1'b0, "R1", "reset mem_we", 64'(mem_we), 0);
        chk(smp_ready == 1'b0, "R1", "reset smp_ready", 64'(smp_ready), 0);
        rst_n = 1'b1;
        // R10: samples while idle, R7: trigger while idle
        step(1, pat(1), 1, 0, 1, 0, 0, 0);
        step(1, pat(2), 1, 0, 0, 0, 0, 0);
        // R2 start, then 20 samples with wrap (R4) and a trigger (R6)
        step(1, pat(3), 1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) step(1, pat(i), 1, 0, i == 5, 0, 0, 0);
        // R5 stall
        for (int i = 0; i < 4; i++) step(1, pat(50 + i), 0, 0, 0, 0, 0, 0);
        // R8 shot end, tags with a stall on the first tag
        step(1, pat(60), 1, 0, 0, 1, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
        step(1, pat(61), 0, 0, 0, 0, 0, 0);
        step(1, pat(62), 1, 0, 0, 0, 0, 0);
        step(1, pat(63), 1, 0, 0, 0, 0, 0);
        step(1, pat(64), 1, 0, 1, 0, 0, 0);
        // R9 start with shot end and trigger together
        step(0, 0, 1, 1, 0, 0, 0, 0);
        step(1, pat(70), 1, 0, 0, 0, 0, 0);
        step(1, pat(71), 1, 1, 1, 1, 64'hDEAD, 64'hBEEF);
        step(1, pat(72), 1, 0, 0, 0, 0, 0);
        step(1, pat(73), 1, 0, 0, 0, 0, 0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 3) != 0, {$urandom, $urandom}, $urandom_range(0, 4) != 0,
                 $urandom_range(0, 60) == 0, $urandom_range(0, 10) == 0,
                 $urandom_range(0, 25) == 0, {$urandom, $urandom}, {$urandom, $urandom});
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule